// File: doc/BRIEF.md
# Converter Sample FIFO with Threshold Flag

This block sits between an analog-to-digital conversion engine and a byte-wide host register port. Each finished conversion presents one 16-bit sample, which the block stores in arrival order. The host drains samples either one byte at a time (low byte, then high byte) or as a single 16-bit word. The host treats each sample as a two's-complement value from -32768 to +32767, and the block passes all 16 bits through unchanged.

The usable depth is either 512 or 1024 samples, chosen by a mode input. The block reports four status bits: empty, threshold reached, full and overflow. The threshold is programmed in units of two samples, so a code of 8 marks 16 stored samples. The block drives a level interrupt request while the threshold bit is set and interrupts are enabled. A one-cycle clear command discards every stored sample and returns the flags to their idle values.

Top module: `sample_fifo`

## Requirements
- R1: With `deepMode`=0 the block holds at most 512 samples, and with `deepMode`=1 it holds at most 1024. Status bit 5 (full) is 1 exactly when the stored count equals the selected depth.
- R2: Status bit 6 (threshold) is 1 exactly when the stored count is greater than or equal to 2 × `thrCode`, where `thrCode` is a 9-bit code.
- R3: Status bit 7 (empty) is 1 exactly when no sample is stored.
- R4: If `wrValid` arrives while full is set, the sample is discarded and status bit 4 (overflow) becomes 1. Overflow stays 1 until a clear or a reset.
- R5: A `fifoRst` pulse discards all stored samples. In the next cycle empty=1, full=0 and overflow=0, and the byte reader returns to the low byte. The clear takes priority over any read or write in the same cycle, and it leaves `dataOut` unchanged.
- R6: On a `rdByte` strobe with the reader at the low byte, the cycle after the strobe shows the head sample's bits 7:0 on `dataOut[7:0]` with the upper bits zero, and the sample stays stored. On the next `rdByte` strobe, bits 15:8 appear the same way and the sample is removed.
- R7: A `rdWord` strobe places the whole 16-bit head sample, signed values included, on `dataOut` in the next cycle. It removes the sample and returns the byte reader to the low byte. If both strobes are high, the word read wins.
- R8: A read strobe while empty leaves `dataOut`, the stored count and the byte reader unchanged.
- R9: `irq` is high exactly while the threshold bit is 1 and `irqEn` is 1.
- R10: A write and a read in the same cycle, with neither blocked, both take effect. Samples always leave in arrival order, including across the wrap of the storage.
- R11: Status bits 3:0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| deepMode | input | 1 | 0 selects a 512-sample depth, 1 selects 1024 |
| wrValid | input | 1 | Store `wrData` this cycle |
| wrData | input | 16 | Sample from the conversion engine |
| rdByte | input | 1 | Byte read strobe (low byte, then high byte) |
| rdWord | input | 1 | Whole-sample read strobe |
| fifoRst | input | 1 | Synchronous clear command |
| irqEn | input | 1 | Interrupt enable |
| thrCode | input | 9 | Threshold in units of two samples |
| dataOut | output | 16 | Last value read (a byte is zero-extended) |
| statusByte | output | 8 | {empty, threshold, full, overflow, 4'b0} |
| irq | output | 1 | Threshold interrupt request (level) |

## Verification
The assertions assume that `deepMode` changes only while the block is empty, because a depth change with samples stored would break the pointer wrap. They also assume that the host never relies on both read strobes being high together. The stimulus changes the mode only directly after a clear, and it raises at most one read strobe per cycle. The threshold code changes only between directed phases, so the flag is always judged against a code that has been stable for the whole phase.

// File: rtl/smpfifo_pkg.sv
package smpfifo_pkg;
  localparam int DATA_W = 16;
  localparam int BYTE_W = 8;
  localparam int LANES  = DATA_W / BYTE_W;

  // Control-to-datapath strobes for one cycle
  typedef struct packed {
    logic clear;
    logic push;
    logic takeLow;
    logic takeHigh;
    logic takeWord;
  } fifoStrobe_t;
endpackage

// File: rtl/smpFifoCtrl.sv
module smpFifoCtrl
  import smpfifo_pkg::*;
#(
  parameter int DEPTH_MAX = 1024,
  parameter int CNT_W     = 11,
  parameter int THR_W     = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             deepMode,
  input  logic             wrValid,
  input  logic             rdByte,
  input  logic             rdWord,
  input  logic             fifoRst,
  input  logic             irqEn,
  input  logic [THR_W-1:0] thrCode,
  output fifoStrobe_t      strobe,
  output logic [7:0]       statusByte,
  output logic             irq
);
  localparam logic [CNT_W-1:0] DEEP_CNT = CNT_W'(DEPTH_MAX);
  localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(DEPTH_MAX / 2);

  logic [CNT_W-1:0] count;
  logic             ovfFlag;
  logic             highNext;
  logic [CNT_W-1:0] depthNow;
  logic [CNT_W-1:0] thrCount;
  logic             fullFlag, emptyFlag, thrFlag;
  logic             popNow;

  assign depthNow  = deepMode ? DEEP_CNT : HALF_CNT;
  assign fullFlag  = (count == depthNow);
  assign emptyFlag = (count == '0);
  assign thrCount  = CNT_W'({thrCode, 1'b0});
  assign thrFlag   = (count >= thrCount);

  always_comb begin
    strobe          = '0;
    strobe.clear    = fifoRst;
    strobe.push     = wrValid && !fullFlag && !fifoRst;
    if (!fifoRst && !emptyFlag) begin
      if (rdWord)          strobe.takeWord = 1'b1;
      else if (rdByte) begin
        if (highNext)      strobe.takeHigh = 1'b1;
        else               strobe.takeLow  = 1'b1;
      end
    end
  end

  assign popNow = strobe.takeWord || strobe.takeHigh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count    <= '0;
      ovfFlag  <= 1'b0;
      highNext <= 1'b0;
    end else if (strobe.clear) begin
      count    <= '0;
      ovfFlag  <= 1'b0;
      highNext <= 1'b0;
    end else begin
      count <= count + CNT_W'(strobe.push) - CNT_W'(popNow);
      if (wrValid && fullFlag) ovfFlag <= 1'b1;
      if (strobe.takeLow)                        highNext <= 1'b1;
      else if (strobe.takeHigh || strobe.takeWord) highNext <= 1'b0;
    end
  end

  assign statusByte = {emptyFlag, thrFlag, fullFlag, ovfFlag, 4'b0000};
  assign irq        = thrFlag && irqEn;
endmodule

// File: rtl/smpFifoData.sv
module smpFifoData
  import smpfifo_pkg::*;
#(
  parameter int DEPTH_MAX = 1024,
  parameter int PTR_W     = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              deepMode,
  input  fifoStrobe_t       strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] dataOut
);
  localparam logic [PTR_W-1:0] DEEP_LAST = PTR_W'(DEPTH_MAX - 1);
  localparam logic [PTR_W-1:0] HALF_LAST = PTR_W'(DEPTH_MAX / 2 - 1);

  logic [DATA_W-1:0] store [DEPTH_MAX];
  logic [PTR_W-1:0]  wrPtr, rdPtr, lastIdx;
  logic [DATA_W-1:0] headWord;
  logic [BYTE_W-1:0] laneByte [LANES];
  logic              popNow;

  assign lastIdx  = deepMode ? DEEP_LAST : HALF_LAST;
  assign headWord = store[rdPtr];
  assign popNow   = strobe.takeWord || strobe.takeHigh;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign laneByte[b] = headWord[b*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (strobe.push) store[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (strobe.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.push) wrPtr <= (wrPtr == lastIdx) ? '0 : wrPtr + 1'b1;
      if (popNow)      rdPtr <= (rdPtr == lastIdx) ? '0 : rdPtr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                dataOut <= '0;
    else if (strobe.takeWord) dataOut <= headWord;
    else if (strobe.takeLow)  dataOut <= {{(DATA_W-BYTE_W){1'b0}}, laneByte[0]};
    else if (strobe.takeHigh) dataOut <= {{(DATA_W-BYTE_W){1'b0}}, laneByte[1]};
  end
endmodule

// File: rtl/sample_fifo.sv
module sample_fifo
  import smpfifo_pkg::*;
#(
  parameter int DEPTH_MAX = 1024
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          deepMode,
  input  logic                          wrValid,
  input  logic [15:0]                   wrData,
  input  logic                          rdByte,
  input  logic                          rdWord,
  input  logic                          fifoRst,
  input  logic                          irqEn,
  input  logic [$clog2(DEPTH_MAX)-2:0]  thrCode,
  output logic [15:0]                   dataOut,
  output logic [7:0]                    statusByte,
  output logic                          irq
);
  localparam int PTR_W = $clog2(DEPTH_MAX);
  localparam int CNT_W = $clog2(DEPTH_MAX + 1);
  localparam int THR_W = PTR_W - 1;

  fifoStrobe_t strobe;

  smpFifoCtrl #(.DEPTH_MAX(DEPTH_MAX), .CNT_W(CNT_W), .THR_W(THR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .deepMode(deepMode), .wrValid(wrValid),
    .rdByte(rdByte), .rdWord(rdWord), .fifoRst(fifoRst), .irqEn(irqEn),
    .thrCode(thrCode), .strobe(strobe), .statusByte(statusByte), .irq(irq)
  );

  smpFifoData #(.DEPTH_MAX(DEPTH_MAX), .PTR_W(PTR_W)) u_data (
    .clk(clk), .rstN(rstN), .deepMode(deepMode), .strobe(strobe),
    .wrData(wrData), .dataOut(dataOut)
  );
endmodule

// File: rtl/smpFifoChk.sv
module smpFifoChk (
  input logic        clk,
  input logic        rstN,
  input logic        deepMode,
  input logic        wrValid,
  input logic        rdByte,
  input logic        rdWord,
  input logic        fifoRst,
  input logic [15:0] dataOut,
  input logic [7:0]  statusByte
);
  // R1 R3
  empty_full_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(statusByte[7] && statusByte[5]));

  // R4
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && statusByte[5] && !fifoRst) |=> statusByte[4]);

  // R4
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[4] && !fifoRst) |=> statusByte[4]);

  // R5
  clear_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoRst |=> (statusByte[7] && !statusByte[5] && !statusByte[4]));

  // R8
  empty_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[7] && (rdByte || rdWord) && !wrValid && !fifoRst)
      |=> ($stable(dataOut) && statusByte[7]));

  // R1: input rule, depth mode held while samples are stored
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!statusByte[7] && !fifoRst) |=> $stable(deepMode));
endmodule

bind sample_fifo smpFifoChk u_chk (
  .clk(clk), .rstN(rstN), .deepMode(deepMode), .wrValid(wrValid),
  .rdByte(rdByte), .rdWord(rdWord), .fifoRst(fifoRst),
  .dataOut(dataOut), .statusByte(statusByte)
);

// File: tb/tb_sample_fifo.sv
`timescale 1ns/1ps
module tb_sample_fifo;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        deepMode = 1'b0;
  logic        wrValid = 1'b0;
  logic [15:0] wrData = '0;
  logic        rdByte = 1'b0;
  logic        rdWord = 1'b0;
  logic        fifoRst = 1'b0;
  logic        irqEn = 1'b0;
  logic [8:0]  thrCode = 9'd4;
  logic [15:0] dataOut;
  logic [7:0]  statusByte;
  logic        irq;

  int checks = 0;
  int failures = 0;
  string curTag = "R5";

  logic [15:0] q[$];
  bit          mOvf = 0;
  bit          mHigh = 0;
  logic [15:0] mOut = '0;

  always #4 clk = ~clk;

  sample_fifo dut (
    .clk(clk), .rstN(rstN), .deepMode(deepMode), .wrValid(wrValid),
    .wrData(wrData), .rdByte(rdByte), .rdWord(rdWord), .fifoRst(fifoRst),
    .irqEn(irqEn), .thrCode(thrCode), .dataOut(dataOut),
    .statusByte(statusByte), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s (phase %s) actual=%0h expected=%0h t=%0t", tag, curTag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    int depth = deepMode ? 1024 : 512;
    int n = q.size();
    bit eEmpty = (n == 0);
    bit eThr = (n >= 2 * int'(thrCode));
    bit eFull = (n == depth);
    chk(statusByte[7] == eEmpty, "R3", 32'(statusByte[7]), 32'(eEmpty));
    chk(statusByte[6] == eThr,   "R2", 32'(statusByte[6]), 32'(eThr));
    chk(statusByte[5] == eFull,  "R1", 32'(statusByte[5]), 32'(eFull));
    chk(statusByte[4] == mOvf,   "R4", 32'(statusByte[4]), 32'(mOvf));
    chk(statusByte[3:0] == 4'h0, "R11", 32'(statusByte[3:0]), 32'h0);
    chk(irq == (eThr && irqEn),  "R9", 32'(irq), 32'(eThr && irqEn));
    chk(dataOut == mOut, "R6_R7_R8_R10 data", 32'(dataOut), 32'(mOut));
  endtask

  // One clock: drive at the falling edge, update the model at the rising edge, compare at the next falling edge
  task automatic cyc(input bit w, input logic [15:0] d, input bit rb, input bit rw, input bit rs);
    int depth;
    bit wasFull, wasEmpty;
    wrValid = w; wrData = d; rdByte = rb; rdWord = rw; fifoRst = rs;
    @(posedge clk);
    depth = deepMode ? 1024 : 512;
    wasFull = (q.size() == depth);
    wasEmpty = (q.size() == 0);
    if (rs) begin
      q.delete(); mOvf = 0; mHigh = 0;
    end else begin
      if (rw && !wasEmpty) begin
        mOut = q.pop_front(); mHigh = 0;
      end else if (rb && !wasEmpty) begin
        if (!mHigh) begin mOut = {8'h00, q[0][7:0]}; mHigh = 1; end
        else begin mOut = {8'h00, q[0][15:8]}; void'(q.pop_front()); mHigh = 0; end
      end
      if (w) begin
        if (wasFull) mOvf = 1;
        else q.push_back(d);
      end
    end
    @(negedge clk);
    compareAll();
  endtask

  task automatic idle(); cyc(0, 16'h0, 0, 0, 0); endtask

  initial begin
    #(8 * 200000);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] v;
    // Reset state (R5, R3)
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(statusByte == 8'h80, "R5 reset status", 32'(statusByte), 32'h80);
    chk(dataOut == 16'h0, "R5 reset data", 32'(dataOut), 32'h0);
    chk(irq == 1'b0, "R9 reset irq", 32'(irq), 32'h0);

    // Threshold at 8 samples, signed extremes, byte and word reads
    curTag = "R2"; irqEn = 1'b1; thrCode = 9'd4;
    cyc(1, 16'h8000, 0, 0, 0);
    cyc(1, 16'h7FFF, 0, 0, 0);
    cyc(1, 16'hFFFF, 0, 0, 0);
    for (int i = 0; i < 7; i++) cyc(1, 16'h1200 + 16'(i), 0, 0, 0);
    chk(irq == 1'b1, "R9 irq at threshold", 32'(irq), 32'h1);
    irqEn = 1'b0; idle();
    chk(irq == 1'b0, "R9 irq masked", 32'(irq), 32'h0);
    irqEn = 1'b1;
    curTag = "R6";
    cyc(0, 0, 1, 0, 0);
    chk(dataOut == 16'h0000, "R6 low byte of 8000", 32'(dataOut), 32'h0);
    cyc(0, 0, 1, 0, 0);
    chk(dataOut == 16'h0080, "R6 high byte of 8000", 32'(dataOut), 32'h80);
    curTag = "R7";
    cyc(0, 0, 1, 0, 0);
    cyc(0, 0, 0, 1, 0);
    chk(dataOut == 16'h7FFF, "R7 word after half byte read", 32'(dataOut), 32'h7FFF);
    cyc(0, 0, 0, 1, 0);
    chk(dataOut == 16'hFFFF, "R7 signed -1 word", 32'(dataOut), 32'hFFFF);
    curTag = "R10";
    for (int i = 0; i < 20; i++) cyc(1, 16'hA000 + 16'(i), 0, 1, 0);
    curTag = "R8";
    while (q.size() > 0) cyc(0, 0, 0, 1, 0);
    v = dataOut;
    cyc(0, 0, 1, 0, 0);
    cyc(0, 0, 0, 1, 0);
    chk(dataOut == v, "R8 empty read holds data", 32'(dataOut), 32'(v));

    // Fill 512 in normal mode, overflow, sticky, clear with same-cycle write
    curTag = "R1"; thrCode = 9'd255;
    for (int i = 0; i < 512; i++) cyc(1, 16'(i * 7), 0, 0, 0);
    chk(statusByte[5] == 1'b1, "R1 full at 512", 32'(statusByte[5]), 32'h1);
    curTag = "R4";
    cyc(1, 16'hDEAD, 0, 0, 0);
    cyc(1, 16'hBEEF, 0, 1, 0);
    cyc(0, 0, 0, 1, 0);
    chk(statusByte[4] == 1'b1, "R4 overflow sticky", 32'(statusByte[4]), 32'h1);
    curTag = "R5";
    cyc(0, 0, 1, 0, 0);
    cyc(1, 16'h5555, 1, 0, 1);
    chk(statusByte == 8'h80, "R5 clear beats write", 32'(statusByte), 32'h80);
    cyc(1, 16'h3412, 0, 0, 0);
    cyc(0, 0, 1, 0, 0);
    chk(dataOut == 16'h0012, "R5 reader back at low byte", 32'(dataOut), 32'h12);
    cyc(0, 0, 0, 0, 1);

    // Deep mode: 1024 samples, threshold code at its top
    curTag = "R1"; deepMode = 1'b1; thrCode = 9'h1FF;
    for (int i = 0; i < 1024; i++) cyc(1, 16'(16'hC000 ^ 16'(i * 13)), 0, 0, 0);
    chk(statusByte[5] == 1'b1, "R1 full at 1024", 32'(statusByte[5]), 32'h1);
    cyc(1, 16'h1111, 0, 0, 0);
    curTag = "R10";
    for (int i = 0; i < 300; i++) cyc(0, 0, 0, 1, 0);
    for (int i = 0; i < 600; i++) cyc(1, 16'(i), (i % 3) == 0, (i % 3) == 1, 0);
    cyc(0, 0, 0, 0, 1);

    // Mixed traffic in both modes
    curTag = "R10";
    for (int m = 0; m < 2; m++) begin
      deepMode = m[0]; thrCode = 9'(40 + m * 100);
      for (int i = 0; i < 6000; i++) begin
        bit w = ($urandom % 100) < 58;
        int r = $urandom % 3;
        cyc(w, 16'($urandom), r == 1, r == 2, 0);
      end
      cyc(0, 0, 0, 0, 1);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule